// File: doc/BRIEF.md
# I2C Slave Receiver with Passive Bus Watch

This block is the receive side of an I2C target, for use inside a larger controller. It oversamples the bus lines with the system clock and pulls SDA low through an open-drain enable only when it acknowledges. It recognises START, repeated START and STOP. After a START it collects an address byte, MSB first. It then acknowledges or stays silent, according to a small control register and a separate own-address register.

Once the block has been addressed, it receives data bytes. Each received byte is latched and announced by a one-cycle interrupt and a sticky pending flag. A passive watch mode lets the block follow any addressed transfer without ever driving the bus. In that mode a read direction is treated as a write, so every byte on the wire reaches software as received data.

Software controls the block through a write strobe, a two-bit register select and a data byte:

- Select 0 writes the control register. Its bits are: bit0 clear, bit1 watch, bit2 general-call refuse, bit3 refuse-acknowledge, bit4 return-to-idle.
- Select 1 writes the own address from data bits [7:1].
- Select 2 with data bit0 set services the pending interrupt.

The clock line is never driven. Slave transmission is not provided: a read addressed to the own address is acknowledged, and then SDA stays released.

Top module: `i2c_watch_slave`

## Requirements
- R1: After reset the control register reads 8'h01. While bit0 (clear) is 1, the block drives nothing, raises no interrupt and holds every status flag at 0, even when its own address is sent. Writing bit0 back to 1 later returns the block to that state.
- R2: With control 8'h00, an own-address write (address byte {own,0}) is acknowledged by SDA low during the ninth clock. A single-cycle irq follows the falling edge that ends that clock, and st_active becomes 1.
- R3: With bit3 (refuse-acknowledge) set, the own address is not acknowledged, no irq is raised and st_active stays 0.
- R4: An address byte that matches neither the own address nor the general call is not acknowledged and raises no irq, and the data bytes that follow are ignored.
- R5: With bit2 (general-call refuse) clear, address byte 8'h00 is acknowledged, raises irq and sets st_gencall.
- R6: With bit2 set, address byte 8'h00 is not acknowledged and raises no irq, and st_active stays 0.
- R7: Once active, each data byte appears on rx_data with one irq at the end of its ninth clock. The byte is acknowledged exactly when bit3 is 0 at the falling edge after its eighth bit.
- R8: With bit1 (watch) set, any address activates the block and raises irq. No address or data byte is ever acknowledged.
- R9: In watch mode, an address byte whose LSB is 1 is handled as a write, so the following bytes are captured on rx_data with an irq each.
- R10: When bit4 (return-to-idle) is 1 and software services a pending interrupt, the block stops responding until the next START, and bit4 reads back 0. st_active keeps its value.
- R11: A STOP clears st_active and ends the transfer. A repeated START restarts address reception at once.
- R12: st_pend is set with every irq and stays set until select 2 is written with data bit0 = 1.
- R13: sda_oe is asserted only during the ninth clock of a byte that is being acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | SCL pull-down enable (always 0) |
| sda_oe | output | 1 | SDA pull-down enable |
| sw_we | input | 1 | Register write strobe |
| sw_sel | input | 2 | Register select: 0 control, 1 own address, 2 service |
| sw_wdata | input | 8 | Register write data |
| ctrl_rd | output | 8 | Control register read value |
| rx_data | output | 8 | Last received byte |
| irq | output | 1 | One-cycle interrupt pulse |
| st_active | output | 1 | Block is an addressed receiver |
| st_gencall | output | 1 | Current transfer is a general call |
| st_pend | output | 1 | Sticky interrupt pending flag |

## Verification
The hardest case to reach is return-to-idle. It only acts when software services an interrupt in the middle of an active transfer, so the bus must pause between bytes while register writes land. The stimulus therefore runs a behavioural master that stops between bytes, performs the register writes, and then sends another byte that must be neither acknowledged nor reported, while st_active still reads 1. A watch-mode read must likewise be driven entirely by the master model, because no target answers. The captured stream is then compared byte for byte against a queue of expected interrupts.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  localparam int ADDR_W  = 7;
  localparam int BYTE_W  = 8;
  localparam int CNT_W   = $clog2(BYTE_W + 1);
  localparam int RTI_BIT = 4;

  localparam logic [BYTE_W-1:0] CTL_RESET = 8'h01;

  localparam logic [1:0] SEL_CTL = 2'd0;
  localparam logic [1:0] SEL_OWN = 2'd1;
  localparam logic [1:0] SEL_ACK = 2'd2;

  // first field is the MSB: bit0 clr ... bit4 rti
  typedef struct packed {
    logic rti;
    logic nak;
    logic gc_nak;
    logic mon;
    logic clr;
  } ctl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_DATA, ST_DATA_ACK, ST_SKIP
  } lnk_state_t;

  typedef struct packed {
    logic take;
    logic ack;
    logic gc;
    logic rw;
  } verdict_t;

  // decide what an address byte means under the current policy bits
  function automatic verdict_t judge_addr(input logic mon, input logic gc_nak,
                                          input logic nak,
                                          input logic [ADDR_W-1:0] own,
                                          input logic [BYTE_W-1:0] ab);
    verdict_t v;
    v = '0;
    if (mon) begin
      v.take = 1'b1;
    end else if (ab == '0) begin
      v.take = !gc_nak;
      v.ack  = !gc_nak;
      v.gc   = !gc_nak;
    end else if (ab[BYTE_W-1:1] == own) begin
      v.take = !nak;
      v.ack  = !nak;
      v.rw   = ab[0];
    end
    return v;
  endfunction

  function automatic logic data_ack(input logic mon, input logic nak);
    return !mon && !nak;
  endfunction

endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall
);
  // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
  logic [STAGES:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-1:0], pin};
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];
endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs
  import i2cw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [1:0]        sw_sel,
  input  logic [BYTE_W-1:0] sw_wdata,
  input  logic              rti_done,
  output ctl_t              ctl,
  output logic [ADDR_W-1:0] own_addr,
  output logic [BYTE_W-1:0] ctrl_rd,
  output logic              ack_pend
);
  localparam int CTL_W = $bits(ctl_t);

  logic [CTL_W-1:0] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q    <= CTL_RESET[CTL_W-1:0];
      own_addr <= OWN_RESET;
    end else begin
      if (sw_we && sw_sel == SEL_CTL) ctl_q <= sw_wdata[CTL_W-1:0];
      else if (rti_done)              ctl_q[RTI_BIT] <= 1'b0;
      if (sw_we && sw_sel == SEL_OWN) own_addr <= sw_wdata[BYTE_W-1:1];
    end
  end

  assign ctl      = ctl_t'(ctl_q);
  assign ctrl_rd  = {{(BYTE_W-CTL_W){1'b0}}, ctl_q};
  assign ack_pend = sw_we && (sw_sel == SEL_ACK) && sw_wdata[0];

  // R10: the return-to-idle request drops once it has acted
  p_rti_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rti_done |=> !ctl_q[RTI_BIT]);
endmodule

// File: rtl/i2cw_link.sv
module i2cw_link
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_t              ctl,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_pend,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              sda_rise,
  input  logic              sda_fall,
  output logic              sda_oe,
  output logic              irq,
  output logic [BYTE_W-1:0] rx_data,
  output logic              st_active,
  output logic              st_gencall,
  output logic              st_pend,
  output logic              rti_done
);
  lnk_state_t        state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              take_q, rw_q, gc_q;

  // named events
  logic     hold, start_ev, stop_ev, shifting, byte_done, slot_end;
  verdict_t verdict;

  assign hold      = ctl.clr;
  assign start_ev  = sda_fall & scl_lvl;
  assign stop_ev   = sda_rise & scl_lvl;
  assign shifting  = (state == ST_ADDR) || (state == ST_DATA);
  assign byte_done = shifting && scl_fall && (cnt == CNT_W'(BYTE_W));
  assign slot_end  = scl_fall && ((state == ST_ADDR_ACK) || (state == ST_DATA_ACK));
  assign verdict   = judge_addr(ctl.mon, ctl.gc_nak, ctl.nak, own_addr, sh);
  assign rti_done  = ctl.rti && ack_pend && st_pend && !hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n || hold) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      sh         <= '0;
      take_q     <= 1'b0;
      rw_q       <= 1'b0;
      gc_q       <= 1'b0;
      sda_oe     <= 1'b0;
      irq        <= 1'b0;
      rx_data    <= '0;
      st_active  <= 1'b0;
      st_gencall <= 1'b0;
      st_pend    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (ack_pend) st_pend <= 1'b0;
      if (start_ev) begin
        state      <= ST_ADDR;
        cnt        <= '0;
        sda_oe     <= 1'b0;
        st_gencall <= 1'b0;
      end else if (stop_ev) begin
        state     <= ST_IDLE;
        sda_oe    <= 1'b0;
        st_active <= 1'b0;
      end else if (rti_done) begin
        state  <= ST_SKIP;
        sda_oe <= 1'b0;
      end else begin
        if (shifting && scl_rise && cnt < CNT_W'(BYTE_W)) begin
          sh  <= {sh[BYTE_W-2:0], sda_lvl};
          cnt <= cnt + 1'b1;
        end
        if (byte_done) begin
          cnt <= '0;
          if (state == ST_ADDR) begin
            sda_oe <= verdict.ack;
            take_q <= verdict.take;
            rw_q   <= verdict.rw;
            gc_q   <= verdict.gc;
            state  <= ST_ADDR_ACK;
          end else begin
            sda_oe <= data_ack(ctl.mon, ctl.nak);
            state  <= ST_DATA_ACK;
          end
        end
        if (slot_end) begin
          sda_oe <= 1'b0;
          if (state == ST_ADDR_ACK) begin
            if (take_q) begin
              st_active  <= 1'b1;
              st_gencall <= gc_q;
              irq        <= 1'b1;
              st_pend    <= 1'b1;
              state      <= rw_q ? ST_SKIP : ST_DATA;
            end else begin
              state <= ST_SKIP;
            end
          end else begin
            rx_data <= sh;
            irq     <= 1'b1;
            st_pend <= 1'b1;
            state   <= ST_DATA;
          end
        end
      end
    end
  end

  // R1: a cleared block stays silent
  p_clear_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (!sda_oe && !irq));
  // R2: interrupt is a single-cycle pulse
  p_irq_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  // R8: watch mode never starts driving SDA
  p_mon_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.mon && !sda_oe) |=> !sda_oe);
  // R11: STOP drops the active flag
  p_stop_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !hold) |=> !st_active);
  // R12: pending flag is sticky until serviced
  p_pend_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st_pend && !ack_pend && !hold) |=> st_pend);
  // R13: SDA is only driven inside an acknowledge slot
  p_oe_in_slot_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !start_ev && !stop_ev && !rti_done && !slot_end) |=>
      (state == ST_ADDR_ACK || state == ST_DATA_ACK));
endmodule

// File: rtl/i2c_watch_slave.sv
module i2c_watch_slave
  import i2cw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] OWN_RESET   = '0,
  parameter int                SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sw_we,
  input  logic [1:0] sw_sel,
  input  logic [7:0] sw_wdata,
  output logic [7:0] ctrl_rd,
  output logic [7:0] rx_data,
  output logic       irq,
  output logic       st_active,
  output logic       st_gencall,
  output logic       st_pend
);
  ctl_t              ctl;
  logic [ADDR_W-1:0] own_addr;
  logic              ack_pend, rti_done;
  logic              scl_lvl, scl_rise, scl_fall;
  logic              sda_lvl, sda_rise, sda_fall;

  assign scl_oe = 1'b0;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .pin(scl_i),
    .lvl(scl_lvl), .rise(scl_rise), .fall(scl_fall));

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .pin(sda_i),
    .lvl(sda_lvl), .rise(sda_rise), .fall(sda_fall));

  i2cw_regs #(.OWN_RESET(OWN_RESET)) u_regs (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .rti_done(rti_done), .ctl(ctl),
    .own_addr(own_addr), .ctrl_rd(ctrl_rd), .ack_pend(ack_pend));

  i2cw_link u_link (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .own_addr(own_addr),
    .ack_pend(ack_pend), .scl_lvl(scl_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .sda_lvl(sda_lvl), .sda_rise(sda_rise),
    .sda_fall(sda_fall), .sda_oe(sda_oe), .irq(irq), .rx_data(rx_data),
    .st_active(st_active), .st_gencall(st_gencall), .st_pend(st_pend),
    .rti_done(rti_done));
endmodule

// File: tb/i2c_watch_slave_test.sv
module i2c_watch_slave_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;   // clocks per quarter bit
  localparam int NONE       = -2;
  localparam int ADDR_IRQ   = -1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_i, sda_i, scl_oe, sda_oe;
  logic       sw_we = 1'b0;
  logic [1:0] sw_sel = 2'd0;
  logic [7:0] sw_wdata = 8'h00;
  logic [7:0] ctrl_rd, rx_data;
  logic       irq, st_active, st_gencall, st_pend;

  int  errors = 0;
  int  checks = 0;
  bit  exp_win = 1'b0;
  bit  irq_prev = 1'b0;
  bit  done = 1'b0;
  int  exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_i = scl_m & ~scl_oe;
  assign sda_i = sda_m & ~sda_oe;

  i2c_watch_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sw_we(sw_we), .sw_sel(sw_sel),
    .sw_wdata(sw_wdata), .ctrl_rd(ctrl_rd), .rx_data(rx_data), .irq(irq),
    .st_active(st_active), .st_gencall(st_gencall), .st_pend(st_pend));

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // reference model, evaluated every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (sda_oe && !exp_win) check(1'b0, "R13 sda_oe outside ack slot", 1, 0);
      if (irq && irq_prev) check(1'b0, "R2 irq wider than one cycle", 1, 0);
      if (irq) begin
        if (exp_q.size() == 0) check(1'b0, "R4 unexpected irq", 1, 0);
        else begin
          int v;
          v = exp_q.pop_front();
          if (v >= 0) check(rx_data == v[7:0], "R7 rx_data", rx_data, v);
        end
      end
      irq_prev = irq;
    end
  end

  task automatic wq(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic sw_write(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic i2c_rstart();
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl_m = 1'b0; wq(1);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; wq(1);
    scl_m = 1'b1; wq(1);
    sda_m = 1'b1; wq(2);
  endtask

  // one byte plus ack slot; irq_kind: NONE, ADDR_IRQ, or the expected rx byte
  task automatic put_byte(input logic [7:0] b, input bit want_ack,
                          input int irq_kind, input string rq);
    bit got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(1);
      scl_m = 1'b1; wq(2);
      if (i == 0 && want_ack) exp_win = 1'b1;
      scl_m = 1'b0;
    end
    if (irq_kind != NONE) exp_q.push_back(irq_kind);
    sda_m = 1'b1; wq(1);
    scl_m = 1'b1; wq(1);
    got = !sda_i;
    wq(1);
    scl_m = 1'b0; wq(1);
    exp_win = 1'b0;
    check(got == want_ack, rq, got, want_ack);
    check(exp_q.size() == 0, {rq, " irq count"}, exp_q.size(), 0);
  endtask

  localparam logic [6:0] OWN = 7'h2A;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check(ctrl_rd == 8'h01, "R1 ctrl reset", ctrl_rd, 8'h01);
    check(!sda_oe && !irq && !st_active && !st_pend && !st_gencall,
          "R1 quiet outputs", {sda_oe, irq, st_active, st_pend}, 0);
    sw_write(2'd1, {OWN, 1'b0});
    i2c_start(); put_byte({OWN, 1'b0}, 1'b0, NONE, "R1 no ack while cleared"); i2c_stop();
    check(!st_active, "R1 inactive", st_active, 0);

    // R2 / R7 / R12 / R11
    sw_write(2'd0, 8'h00);
    i2c_start();
    put_byte({OWN, 1'b0}, 1'b1, ADDR_IRQ, "R2 own address ack");
    check(st_active && st_pend, "R2 active and R12 pend", {st_active, st_pend}, 3);
    put_byte(8'hA5, 1'b1, 8'hA5, "R7 data ack");
    sw_write(2'd2, 8'h01);
    check(!st_pend, "R12 pend cleared by service", st_pend, 0);
    sw_write(2'd0, 8'h08);
    put_byte(8'h3C, 1'b0, 8'h3C, "R7 data nak by policy");
    check(st_pend, "R12 pend set again", st_pend, 1);
    i2c_stop();
    check(!st_active, "R11 stop clears active", st_active, 0);
    sw_write(2'd2, 8'h01);

    // R3 refuse own address
    i2c_start(); put_byte({OWN, 1'b0}, 1'b0, NONE, "R3 own address refused"); i2c_stop();
    check(!st_active && !st_pend, "R3 stays inactive", {st_active, st_pend}, 0);

    // R4 foreign address and following data ignored
    sw_write(2'd0, 8'h00);
    i2c_start();
    put_byte({7'h22, 1'b0}, 1'b0, NONE, "R4 foreign address");
    put_byte(8'h66, 1'b0, NONE, "R4 data ignored");
    i2c_stop();
    check(rx_data == 8'h3C, "R4 rx_data untouched", rx_data, 8'h3C);

    // R5 general call accepted
    i2c_start();
    put_byte(8'h00, 1'b1, ADDR_IRQ, "R5 general call ack");
    check(st_gencall && st_active, "R5 gencall flag", {st_gencall, st_active}, 3);
    put_byte(8'h11, 1'b1, 8'h11, "R5 general call data");
    i2c_stop();
    sw_write(2'd2, 8'h01);

    // R6 general call refused
    sw_write(2'd0, 8'h04);
    i2c_start(); put_byte(8'h00, 1'b0, NONE, "R6 general call refused"); i2c_stop();
    check(!st_active && !st_gencall, "R6 inactive", {st_active, st_gencall}, 0);

    // R8 watch mode, write direction
    sw_write(2'd0, 8'h02);
    i2c_start();
    put_byte(8'h90, 1'b0, ADDR_IRQ, "R8 watch address not acked");
    check(st_active, "R8 watch becomes active", st_active, 1);
    put_byte(8'h01, 1'b0, 8'h01, "R8 watch byte 1");
    put_byte(8'h80, 1'b0, 8'h80, "R8 watch byte 2");
    i2c_stop();

    // R9 watch mode, read direction captured as received
    i2c_start();
    put_byte({OWN, 1'b1}, 1'b0, ADDR_IRQ, "R9 watch read address");
    put_byte(8'hDE, 1'b0, 8'hDE, "R9 read byte 1");
    put_byte(8'hAD, 1'b0, 8'hAD, "R9 read byte 2");
    i2c_stop();
    sw_write(2'd2, 8'h01);

    // R11 repeated start
    sw_write(2'd0, 8'h00);
    i2c_start();
    put_byte({7'h11, 1'b0}, 1'b0, NONE, "R11 first address foreign");
    i2c_rstart();
    put_byte({OWN, 1'b0}, 1'b1, ADDR_IRQ, "R11 restart own address");
    put_byte(8'h42, 1'b1, 8'h42, "R11 data after restart");
    i2c_stop();
    sw_write(2'd2, 8'h01);

    // R10 return to idle
    i2c_start();
    put_byte({OWN, 1'b0}, 1'b1, ADDR_IRQ, "R10 address");
    put_byte(8'h5A, 1'b1, 8'h5A, "R10 data before return");
    sw_write(2'd0, 8'h10);
    check(ctrl_rd == 8'h10, "R10 request reads back", ctrl_rd, 8'h10);
    sw_write(2'd2, 8'h01);
    check(ctrl_rd == 8'h00, "R10 self-clears", ctrl_rd, 8'h00);
    check(st_active && !st_pend, "R10 active kept", {st_active, st_pend}, 2);
    put_byte(8'h77, 1'b0, NONE, "R10 idle after service");
    check(rx_data == 8'h5A, "R10 rx_data untouched", rx_data, 8'h5A);
    i2c_stop();
    check(!st_active, "R11 stop after return", st_active, 0);

    // R1 clear again
    sw_write(2'd0, 8'h01);
    i2c_start(); put_byte({OWN, 1'b0}, 1'b0, NONE, "R1 clear rewritten"); i2c_stop();
    check(ctrl_rd == 8'h01 && !st_active, "R1 held cleared", ctrl_rd, 8'h01);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule